// File: doc/BRIEF.md
# Channel Trigger Data Framer

The framer turns per-channel pulse reports into one fixed-width word per channel per frame, ready for a serial trigger link. Internal work advances on a 4 ns processing tick (a `tick_en` strobe), and eight ticks make one 32 ns frame. When a channel reports a pulse, the block stores the pulse energy, clipped to the width of the word's energy field, together with the index (0 to 7) of the tick within the frame on which the pulse arrived. A receiver that sees only one word per 32 ns can therefore rebuild the pulse time to 4 ns.

When the eighth tick of a frame completes, the words of all channels are presented together as one parallel frame on a valid/ready output. The inputs cannot stall, because time runs on, so the output is not allowed to hold back the input side. A frame stays on the output, unchanged, until it is accepted. A frame that completes while the previous one is still waiting is discarded, and the waiting frame is kept. With `out_ready` held high, `out_valid` is a single-cycle pulse once per frame.

A parameter selects a narrow variant that packs a 5-bit energy with the same 3 timing bits into one byte per channel.

Top module: `chan_trig_framer`

## Requirements
- R1: After reset, `out_valid` is 0, `out_frame` is all zeros, and the tick index is 0.
- R2: The tick index advances by one, modulo 8, only in cycles where `tick_en` is 1. A frame ends on the `tick_en` cycle whose index is 7, so cycles with `tick_en` low do not shorten a frame.
- R3: `frame_start` high together with `tick_en` makes the current tick index 0. Any pulse already held for the partial frame is discarded.
- R4: Each word carries the tick index in bits [2:0] and the energy in the bits above them. The energy field is bits [15:3] in the default mode.
- R5: An input energy above the field maximum is stored as all ones in the field. Values at or below the maximum are stored unchanged.
- R6: A channel that takes no pulse during a frame sends an all-zero word.
- R7: Only the first pulse a channel takes in a frame is kept. Later pulses on that channel in the same frame are ignored.
- R8: `out_valid` rises in the cycle after the clock edge of a frame's last tick. Channel c's word sits at `out_frame[c*W +: W]`, and pulses taken on that last tick are included.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_frame` hold. A frame that completes in that state is dropped. A transfer happens on an edge with both flags high.
- R10: With `NARROW` set to 1, each word is 8 bits wide, with the energy saturated to 5 bits in [7:3] and the tick index in [2:0].
- R11: `pulse_vld` and `frame_start` have no effect in cycles where `tick_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | 4 ns processing tick strobe |
| frame_start | input | 1 | Forces tick index 0 on a tick |
| pulse_vld | input | N_CH | Per-channel pulse report |
| pulse_energy | input | N_CH*E_IN_W | Per-channel pulse energy, channel c at [c*E_IN_W +: E_IN_W] |
| out_valid | output | 1 | Frame available |
| out_ready | input | 1 | Receiver accepts the frame |
| out_frame | output | N_CH*W | Packed channel words, W = 16 or 8 |

## Verification
Every result is due exactly one clock edge after the tick that produces it. A pulse on the last tick, and the closing of the frame, both appear on `out_valid`/`out_frame` after the next rising edge. An accept by `out_ready` clears the flag at the same edge. The bench drives inputs on falling edges and keeps a per-tick behavioural model that it updates on each rising edge. It compares the outputs of both the default and the narrow instance against that model on every falling edge, which lands each comparison half a cycle after the edge that is due to change the result. Directed checks read the first frame after a known pulse pattern at that same point.

// File: rtl/chan_framer_pkg.sv
package chan_framer_pkg;
  localparam int TICK_W          = 3;
  localparam int TICKS_PER_FRAME = 1 << TICK_W;
  localparam int WIDE_E_W        = 13;
  localparam int NARROW_E_W      = 5;

  function automatic int energy_w(input bit narrow);
    return narrow ? NARROW_E_W : WIDE_E_W;
  endfunction
endpackage

// File: rtl/tick_phase.sv
module tick_phase
  import chan_framer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              frame_start,
  output logic [TICK_W-1:0] cur_tick,
  output logic              last_tick
);
  logic [TICK_W-1:0] cnt_q;

  assign cur_tick  = (tick_en && frame_start) ? '0 : cnt_q;
  assign last_tick = tick_en && (cur_tick == {TICK_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick_en) cnt_q <= cur_tick + TICK_W'(1);
  end

  // R3
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && frame_start |=> cnt_q == TICK_W'(1));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_q));
endmodule

// File: rtl/chan_capture.sv
module chan_capture
  import chan_framer_pkg::*;
#(
  parameter int E_IN_W = 16,
  parameter int E_W    = 13,
  localparam int WORD_W = E_W + TICK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic [TICK_W-1:0] cur_tick,
  input  logic              pulse_vld,
  input  logic [E_IN_W-1:0] energy_in,
  output logic [WORD_W-1:0] word_eff
);
  localparam logic [E_IN_W-1:0] MAX_IN = E_IN_W'((1 << E_W) - 1);

  logic              held_q, base_held, take, held_eff;
  logic [WORD_W-1:0] word_q;
  logic [E_W-1:0]    e_sat;

  assign base_held = (tick_en && frame_start) ? 1'b0 : held_q;
  assign take      = tick_en && pulse_vld && !base_held;
  assign e_sat     = (energy_in > MAX_IN) ? {E_W{1'b1}} : energy_in[E_W-1:0];
  assign held_eff  = base_held | take;

  always_comb begin
    if (take)           word_eff = {e_sat, cur_tick};
    else if (base_held) word_eff = word_q;
    else                word_eff = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      word_q <= '0;
    end else if (frame_end) begin
      held_q <= 1'b0;
      word_q <= '0;
    end else begin
      held_q <= held_eff;
      word_q <= word_eff;
    end
  end

  // R7
  first_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held_q && !(tick_en && (frame_start || frame_end)) |=> held_q && $stable(word_q));

  // R11
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(word_q) && $stable(held_q));
endmodule

// File: rtl/frame_out_stage.sv
module frame_out_stage #(
  parameter int FRAME_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_end,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [FRAME_W-1:0] out_frame
);
  logic load;

  assign load = frame_end && (!out_valid || out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_frame <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_frame <= frame_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_frame));

  // R8
  valid_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(frame_end));
endmodule

// File: rtl/chan_trig_framer.sv
module chan_trig_framer
  import chan_framer_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int E_IN_W = 16,
  parameter bit NARROW = 1'b0,
  localparam int E_W     = energy_w(NARROW),
  localparam int WORD_W  = E_W + TICK_W,
  localparam int FRAME_W = N_CH * WORD_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_en,
  input  logic                     frame_start,
  input  logic [N_CH-1:0]          pulse_vld,
  input  logic [N_CH*E_IN_W-1:0]   pulse_energy,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [FRAME_W-1:0]       out_frame
);
  logic [TICK_W-1:0]  cur_tick;
  logic               last_tick;
  logic [FRAME_W-1:0] frame_eff;

  tick_phase u_phase (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .frame_start(frame_start),
    .cur_tick(cur_tick), .last_tick(last_tick)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    chan_capture #(.E_IN_W(E_IN_W), .E_W(E_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .frame_start(frame_start),
      .frame_end(last_tick), .cur_tick(cur_tick), .pulse_vld(pulse_vld[c]),
      .energy_in(pulse_energy[c*E_IN_W +: E_IN_W]),
      .word_eff(frame_eff[c*WORD_W +: WORD_W])
    );
  end

  frame_out_stage #(.FRAME_W(FRAME_W)) u_out (
    .clk(clk), .rst_n(rst_n), .frame_end(last_tick), .frame_in(frame_eff),
    .out_ready(out_ready), .out_valid(out_valid), .out_frame(out_frame)
  );
endmodule

// File: tb/chan_trig_framer_tb.sv
module chan_trig_framer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int EW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic te = 1'b0, fs = 1'b0, rdy = 1'b1;
  logic [N-1:0]    pv = '0;
  logic [N*EW-1:0] pe = '0;
  logic            ov_w, ov_n;
  logic [N*16-1:0] of_w;
  logic [N*8-1:0]  of_n;

  int n_chk = 0, n_fail = 0;
  string cur_tag = "R8";

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_trig_framer #(.N_CH(N), .E_IN_W(EW), .NARROW(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(te), .frame_start(fs), .pulse_vld(pv),
    .pulse_energy(pe), .out_valid(ov_w), .out_ready(rdy), .out_frame(of_w));

  chan_trig_framer #(.N_CH(N), .E_IN_W(EW), .NARROW(1'b1)) dut_n_i (
    .clk(clk), .rst_n(rst_n), .tick_en(te), .frame_start(fs), .pulse_vld(pv),
    .pulse_energy(pe), .out_valid(ov_n), .out_ready(rdy), .out_frame(of_n));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_cnt; bit m_held[N]; int m_e[N]; int m_t[N]; bit m_ov;
  logic [N*16-1:0] m_fw; logic [N*8-1:0] m_fn;

  function automatic int sat(input int e, input int mx);
    return (e > mx) ? mx : e;
  endfunction

  always @(posedge clk) begin
    bit last; int cur;
    if (!rst_n) begin
      m_cnt = 0; m_ov = 0; m_fw = '0; m_fn = '0;
      for (int c = 0; c < N; c++) m_held[c] = 0;
    end else begin
      last = 0;
      if (te) begin
        cur = fs ? 0 : m_cnt;
        if (fs) for (int c = 0; c < N; c++) m_held[c] = 0;
        for (int c = 0; c < N; c++)
          if (pv[c] && !m_held[c]) begin
            m_held[c] = 1; m_e[c] = int'(pe[c*EW +: EW]); m_t[c] = cur;
          end
        last = (cur == 7);
        m_cnt = (cur + 1) % 8;
      end
      if (last && (!m_ov || rdy)) begin
        m_ov = 1;
        for (int c = 0; c < N; c++) begin
          m_fw[c*16 +: 16] = m_held[c] ? 16'((sat(m_e[c], 8191) << 3) | m_t[c]) : 16'd0;
          m_fn[c*8 +: 8]   = m_held[c] ? 8'((sat(m_e[c], 31) << 3) | m_t[c]) : 8'd0;
        end
      end else if (rdy) m_ov = 0;
      if (last) for (int c = 0; c < N; c++) m_held[c] = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(ov_w == m_ov, cur_tag, 64'(ov_w), 64'(m_ov));
      chk(ov_n == m_ov, {cur_tag, " R10"}, 64'(ov_n), 64'(m_ov));
      if (m_ov) begin
        chk(of_w == m_fw, cur_tag, of_w, m_fw);
        chk(of_n == m_fn, {cur_tag, " R10"}, 64'(of_n), 64'(m_fn));
      end
    end
  end

  task automatic step(input logic t, input logic f, input logic [N-1:0] p);
    @(negedge clk);
    te = t; fs = f; pv = p;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ov_w == 1'b0 && of_w == '0, "R1", 64'(ov_w), 64'd0);
    chk(ov_n == 1'b0 && of_n == '0, "R1", 64'(ov_n), 64'd0);
    rst_n = 1'b1;

    // directed frame: R4 R5 R6 R7 R8 R10
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      te = 1; fs = (k == 0); pv = '0; pe = '0;
      if (k == 5) begin pv[0] = 1; pe[0*EW +: EW] = 16'd100; end
      if (k == 2) begin pv[1] = 1; pe[1*EW +: EW] = 16'd20000; end
      if (k == 1) begin pv[3] = 1; pe[3*EW +: EW] = 16'd7; end
      if (k == 4) begin pv[3] = 1; pe[3*EW +: EW] = 16'd50; end
    end
    @(negedge clk);
    te = 0; fs = 0; pv = '0;
    chk(ov_w == 1'b1, "R8", 64'(ov_w), 64'd1);
    chk(of_w[15:0] == 16'd805, "R4", 64'(of_w[15:0]), 64'd805);
    chk(of_w[31:16] == 16'd65530, "R5", 64'(of_w[31:16]), 64'd65530);
    chk(of_w[47:32] == 16'd0, "R6", 64'(of_w[47:32]), 64'd0);
    chk(of_w[63:48] == 16'd57, "R7", 64'(of_w[63:48]), 64'd57);
    chk(of_n == {8'd57, 8'd0, 8'd250, 8'd253}, "R10", 64'(of_n), 64'h3900FAFD);
    @(negedge clk);
    chk(ov_w == 1'b0, "R8", 64'(ov_w), 64'd0);

    // gapped ticks, pulses on idle cycles must be ignored
    cur_tag = "R2 R11";
    for (int k = 0; k < 48; k++) begin
      @(negedge clk);
      te = (k % 2 == 0); fs = (k % 7 == 3);
      pv = 4'((k * 5 + 3) % 16);
      for (int c = 0; c < N; c++) pe[c*EW +: EW] = 16'((k * 997 + c * 4099) % 65536);
    end

    // restart mid-frame
    cur_tag = "R3";
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      te = 1; fs = (k == 3) || (k == 21) || (k == 26);
      pv = 4'((k * 3 + 1) % 16);
      for (int c = 0; c < N; c++) pe[c*EW +: EW] = 16'((k * 131 + c * 17) % 9000);
    end

    // back-pressure: hold and drop
    cur_tag = "R9";
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      te = 1; fs = 0; rdy = !(k >= 4 && k < 26);
      pv = 4'((k * 7 + 2) % 16);
      for (int c = 0; c < N; c++) pe[c*EW +: EW] = 16'((k * 211 + c * 53) % 12000);
    end
    rdy = 1; pv = '0; te = 0;
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule